// File: doc/BRIEF.md
# Bit-Field Manipulation Unit

This execution unit performs bit-field operations on a 32-bit word for a processor pipeline. One instruction is accepted per cycle along with the three operand values read for it: the first source, the second source, and the present contents of the destination register. One cycle later the unit returns a result word and a write enable. The operations are:

- signed and unsigned field extraction;
- field insertion into the existing destination value;
- setting or clearing a field;
- sign or zero extension of the low byte or the low halfword.

Field bounds are given as a start bit and a length-minus-one. They come either from immediate fields of the instruction or from the low ten bits of the second source. An operation whose field would extend more than one bit past the top of the word is suppressed. When that happens the destination keeps its old value.

Top module: `bitfield_unit`

## Requirements
- R1: After reset, `out_valid` and `out_we` are 0. Every accepted instruction (`in_valid` high at a rising edge) produces `out_valid` high exactly one cycle later, and `out_we` is never high without `out_valid`.
- R2: Only instructions with bits 6:0 equal to 0110011 are recognised. The immediate form has bits 31:30 = 11, the length-minus-one in bits 29:25 and the start bit in bits 24:20. The register form has bits 31:25 = 1000000, takes the start from `src_b[4:0]` and the length-minus-one from `src_b[9:5]`, and ignores `src_b[31:10]`. Any other word gives `out_we` = 0.
- R3: In both field forms, bits 14:12 select the operation: 000 signed extract, 001 unsigned extract, 010 insert, 011 clear, 100 set. The codes 101, 110 and 111 give `out_we` = 0.
- R4: Set returns `src_a` OR a mask of length-minus-one+1 ones shifted left by the start bit. Clear returns `src_a` AND the inverse of that mask. Mask bits above bit 31 are dropped.
- R5: Insert returns `dst_old` OR (the low length-minus-one+1 bits of `src_a`, shifted left by the start bit), truncated to 32 bits.
- R6: Unsigned extract returns the field of `src_a` that begins at the start bit, right-aligned and zero-filled.
- R7: Signed extract returns the same field, sign-extended from the top bit of the field. If the field runs past bit 31, only the bits up to bit 31 take part, and bit 31 becomes the sign.
- R8: With bits 31:20 = 0x100 and bits 14:12 equal to 100, 101, 110 or 111, the result is, respectively, the sign-extended low halfword, the zero-extended low halfword, the sign-extended low byte, or the zero-extended low byte of `src_a`.
- R9: In a field form, if start + length-minus-one exceeds 32, `out_we` is 0.
- R10: Whenever `out_valid` is high and `out_we` is low, `out_data` equals the `dst_old` presented with that instruction.
- R11: A cycle with `in_valid` low gives `out_valid` = 0 and `out_we` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | First source operand |
| src_b | input | 32 | Second source operand (packed field bounds in register form) |
| dst_old | input | 32 | Current destination register value |
| out_valid | output | 1 | Result slot is valid |
| out_we | output | 1 | Result should be written to the destination |
| out_data | output | 32 | Result word (old destination value when not written) |

## Verification
All decode and mask state is recomputed for every instruction, so a fault cannot persist. A wrong decode, a wrong mask bound or a wrong sign-bit choice shows up as a wrong `out_data` or `out_we` in the cycle right after the instruction is offered. The sweep covers every start and length pair, in both field forms, for each of the five field operations. This exposes off-by-one errors at the mask edges, the boundary at a sum of exactly 32 against 33, and a sign bit taken from the wrong position. Random operand values make sure that stuck or swapped bits in the data path reach the output.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam logic [6:0] OPC_ALU_REG = 7'b0110011;

  typedef enum logic [3:0] {
    BFU_NOP,
    BFU_EXT_S,
    BFU_EXT_U,
    BFU_INS,
    BFU_CLR,
    BFU_SET,
    BFU_SXH,
    BFU_ZXH,
    BFU_SXB,
    BFU_ZXB
  } bfu_op_e;

endpackage

// File: rtl/bfu_decode.sv
module bfu_decode
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_b,
  output bfu_op_e           op,
  output logic [POS_W-1:0]  pos,
  output logic [POS_W-1:0]  lenm1,
  output logic              in_range
);

  logic       is_alu, imm_form, reg_form, ext_form;
  logic [2:0] f3;
  logic [POS_W:0] span;
  logic unused_bits;

  assign unused_bits = ^{instr[19:7], src_b[DATA_W-1:2*POS_W]};

  assign is_alu   = (instr[6:0] == OPC_ALU_REG);
  assign imm_form = (instr[31:30] == 2'b11);
  assign reg_form = (instr[31:25] == 7'b1000000);
  assign ext_form = (instr[31:20] == 12'h100);
  assign f3       = instr[14:12];

  always_comb begin
    if (reg_form) begin
      pos   = src_b[POS_W-1:0];
      lenm1 = src_b[2*POS_W-1:POS_W];
    end else begin
      pos   = instr[20 +: POS_W];
      lenm1 = instr[25 +: POS_W];
    end
  end

  always_comb begin
    op = BFU_NOP;
    if (is_alu && (imm_form || reg_form)) begin
      unique case (f3)
        3'b000:  op = BFU_EXT_S;
        3'b001:  op = BFU_EXT_U;
        3'b010:  op = BFU_INS;
        3'b011:  op = BFU_CLR;
        3'b100:  op = BFU_SET;
        default: op = BFU_NOP;
      endcase
    end else if (is_alu && ext_form && f3[2]) begin
      unique case (f3[1:0])
        2'b00:   op = BFU_SXH;
        2'b01:   op = BFU_ZXH;
        2'b10:   op = BFU_SXB;
        default: op = BFU_ZXB;
      endcase
    end
  end

  assign span     = {1'b0, pos} + {1'b0, lenm1};
  assign in_range = (span <= (POS_W+1)'(DATA_W));

endmodule

// File: rtl/bfu_mask.sv
module bfu_mask #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  lenm1,
  output logic [DATA_W-1:0] field_mask,
  output logic [DATA_W-1:0] low_mask,
  output logic [POS_W-1:0]  top_idx
);

  logic [POS_W-1:0] room;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    localparam logic [POS_W:0] IDX = (POS_W+1)'(i);
    assign low_mask[i]   = (IDX <= {1'b0, lenm1});
    assign field_mask[i] = (IDX >= {1'b0, pos}) &&
                           ((IDX - {1'b0, pos}) <= {1'b0, lenm1});
  end

  assign room    = POS_W'(DATA_W-1) - pos;
  assign top_idx = (lenm1 < room) ? lenm1 : room;

  always_comb begin
    if (({1'b0, pos} + {1'b0, lenm1}) <= (POS_W+1)'(DATA_W-1)) begin
      AST_MASK_COUNT: assert ($countones(field_mask) == int'(lenm1) + 1); // R4
    end
  end

endmodule

// File: rtl/bfu_datapath.sv
module bfu_datapath
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W  = $clog2(DATA_W),
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned BYTE_W = 8
) (
  input  bfu_op_e           op,
  input  logic [POS_W-1:0]  pos,
  input  logic [POS_W-1:0]  top_idx,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [DATA_W-1:0] field_mask,
  input  logic [DATA_W-1:0] low_mask,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] shifted, ext_u, ext_s, ins_val;
  logic              sign_bit;

  assign shifted  = src_a >> pos;
  assign sign_bit = shifted[top_idx];

  for (genvar i = 0; i < DATA_W; i++) begin : g_ext
    localparam logic [POS_W-1:0] IDX = POS_W'(i);
    assign ext_u[i] = (IDX <= top_idx) & shifted[i];
    assign ext_s[i] = (IDX <= top_idx) ? shifted[i] : sign_bit;
  end

  assign ins_val = dst_old | ((src_a & low_mask) << pos);

  always_comb begin
    unique case (op)
      BFU_EXT_S: result = ext_s;
      BFU_EXT_U: result = ext_u;
      BFU_INS:   result = ins_val;
      BFU_CLR:   result = src_a & ~field_mask;
      BFU_SET:   result = src_a | field_mask;
      BFU_SXH:   result = {{(DATA_W-HALF_W){src_a[HALF_W-1]}}, src_a[HALF_W-1:0]};
      BFU_ZXH:   result = {{(DATA_W-HALF_W){1'b0}}, src_a[HALF_W-1:0]};
      BFU_SXB:   result = {{(DATA_W-BYTE_W){src_a[BYTE_W-1]}}, src_a[BYTE_W-1:0]};
      BFU_ZXB:   result = {{(DATA_W-BYTE_W){1'b0}}, src_a[BYTE_W-1:0]};
      default:   result = dst_old;
    endcase
  end

  always_comb begin
    if (op == BFU_SET) begin
      AST_SET_KEEPS_ONES: assert ((result & src_a) == src_a); // R4
    end
    if (op == BFU_CLR) begin
      AST_CLR_KEEPS_ZEROS: assert ((result | src_a) == src_a); // R4
    end
    if (op == BFU_INS) begin
      AST_INS_KEEPS_DEST: assert ((result & dst_old) == dst_old); // R5
    end
  end

endmodule

// File: rtl/bitfield_unit.sv
module bitfield_unit
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned POS_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [DATA_W-1:0] dst_old,
  output logic              out_valid,
  output logic              out_we,
  output logic [DATA_W-1:0] out_data
);

  bfu_op_e           op;
  logic [POS_W-1:0]  pos, lenm1, top_idx;
  logic              in_range;
  logic [DATA_W-1:0] field_mask, low_mask, result;

  logic              valid_d, we_d;
  logic [DATA_W-1:0] data_d;

  bfu_decode #(.DATA_W(DATA_W)) u_decode (
    .instr    (instr),
    .src_b    (src_b),
    .op       (op),
    .pos      (pos),
    .lenm1    (lenm1),
    .in_range (in_range)
  );

  bfu_mask #(.DATA_W(DATA_W)) u_mask (
    .pos        (pos),
    .lenm1      (lenm1),
    .field_mask (field_mask),
    .low_mask   (low_mask),
    .top_idx    (top_idx)
  );

  bfu_datapath #(.DATA_W(DATA_W)) u_dp (
    .op         (op),
    .pos        (pos),
    .top_idx    (top_idx),
    .src_a      (src_a),
    .dst_old    (dst_old),
    .field_mask (field_mask),
    .low_mask   (low_mask),
    .result     (result)
  );

  always_comb begin
    valid_d = in_valid;
    we_d    = in_valid && (op != BFU_NOP) && in_range;
    data_d  = we_d ? result : dst_old;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_we    <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_we    <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (in_valid) begin
      out_data <= data_d;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R1
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_we |-> out_valid); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !out_we)); // R11
  AST_UNKNOWN_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == BFU_NOP) |=> !out_we); // R2
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_range) |=> !out_we); // R9
  AST_KEEP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_we || out_data == $past(dst_old))); // R10

endmodule

// File: tb/sim_bitfield_unit.sv
module sim_bitfield_unit;

  logic        clk, rst_n, in_valid;
  logic [31:0] instr, src_a, src_b, dst_old;
  logic        out_valid, out_we;
  logic [31:0] out_data;

  int n_run, n_fail;
  logic [31:0] seed;

  bitfield_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .src_a(src_a), .src_b(src_b), .dst_old(dst_old),
    .out_valid(out_valid), .out_we(out_we), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] rnd();
    logic [31:0] x = seed;
    x ^= x << 13;
    x ^= x >> 17;
    x ^= x << 5;
    seed = x;
    return x;
  endfunction

  function automatic logic [31:0] enc_imm(int f3, int p, int l);
    return {2'b11, 5'(l), 5'(p), 5'd3, 3'(f3), 5'd9, 7'b0110011};
  endfunction

  function automatic logic [31:0] enc_reg(int f3);
    return {7'b1000000, 5'd4, 5'd3, 3'(f3), 5'd9, 7'b0110011};
  endfunction

  // Reference: returns {we, data}
  function automatic logic [32:0] model(int f3, int p, int l, logic [31:0] a, logic [31:0] d);
    logic [63:0] m64, fm, t, s;
    int ew;
    if (p + l > 32 || f3 > 4) return {1'b0, d};
    m64 = (64'd1 << (l + 1)) - 64'd1;
    fm  = m64 << p;
    t   = ({32'd0, a} >> p) & m64;
    ew  = (l + 1 < 32 - p) ? l + 1 : 32 - p;
    s   = t[ew-1] ? (t | (~64'd0 << ew)) : t;
    case (f3)
      0: return {1'b1, s[31:0]};
      1: return {1'b1, t[31:0]};
      2: return {1'b1, d | 32'((a & m64[31:0]) << p)};
      3: return {1'b1, a & ~fm[31:0]};
      default: return {1'b1, a | fm[31:0]};
    endcase
  endfunction

  task automatic check(input string tag, input logic ev, input logic ew,
                       input logic [31:0] ed);
    n_run++;
    if (out_valid !== ev || out_we !== ew || (ev && out_data !== ed)) begin
      n_fail++;
      $display("FAIL %s: valid/we/data = %b/%b/%h, expected %b/%b/%h",
               tag, out_valid, out_we, out_data, ev, ew, ed);
    end
  endtask

  task automatic issue(input logic [31:0] ins, a, b, d, input string tag,
                       input logic ew, input logic [31:0] ed);
    @(negedge clk);
    in_valid = 1'b1; instr = ins; src_a = a; src_b = b; dst_old = d;
    @(negedge clk);
    in_valid = 1'b0;
    check(tag, 1'b1, ew, ed);
  endtask

  initial begin
    #800000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, actual hung, expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [32:0] e;
    logic [31:0] a, d, b;
    n_run = 0; n_fail = 0; seed = 32'h1234_5678;
    rst_n = 1'b0; in_valid = 1'b0; instr = '0; src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    check("R1 reset state", 1'b0, 1'b0, 32'h0);
    rst_n = 1'b1;

    // Immediate form: full sweep of start and length for each field op
    for (int f3 = 0; f3 < 5; f3++)
      for (int p = 0; p < 32; p++)
        for (int l = 0; l < 32; l++) begin
          a = rnd(); d = rnd();
          e = model(f3, p, l, a, d);
          issue(enc_imm(f3, p, l), a, rnd(), d,
                $sformatf("R3/R4/R5/R6/R7/R9 imm f3=%0d p=%0d l=%0d", f3, p, l), e[32], e[31:0]);
        end

    // Register form: bounds in src_b, upper bits of src_b are junk (R2)
    for (int f3 = 0; f3 < 5; f3++)
      for (int p = 0; p < 32; p++)
        for (int l = 0; l < 32; l++) begin
          a = rnd(); d = rnd();
          b = {rnd() >> 10, 5'(l), 5'(p)};
          e = model(f3, p, l, a, d);
          issue(enc_reg(f3), a, b, d,
                $sformatf("R2/R9 reg f3=%0d p=%0d l=%0d", f3, p, l), e[32], e[31:0]);
        end

    // Signed extract: sign from top of field, and field crossing bit 31 (R7)
    issue(enc_imm(0, 4, 3), 32'h0000_0080, 0, 32'h5, "R7 sign at top", 1'b1, 32'hFFFF_FFF8);
    issue(enc_imm(0, 4, 3), 32'h0000_0070, 0, 32'h5, "R7 positive", 1'b1, 32'h0000_0007);
    issue(enc_imm(0, 30, 2), 32'h8000_0000, 0, 32'h5, "R7 crosses bit 31", 1'b1, 32'hFFFF_FFFE);
    // Boundary: sum 32 allowed, 33 not (R9)
    issue(enc_imm(4, 31, 1), 32'h0, 0, 32'h5, "R9 sum 32 allowed", 1'b1, 32'h8000_0000);
    issue(enc_imm(4, 31, 2), 32'h0, 0, 32'hCAFE_0001, "R9 R10 sum 33 blocked", 1'b0, 32'hCAFE_0001);

    // Unused funct3 codes in field forms (R3)
    for (int f3 = 5; f3 < 8; f3++) begin
      issue(enc_imm(f3, 2, 2), 32'hFFFF_FFFF, 0, 32'h1111_2222, "R3 R10 unused imm code", 1'b0, 32'h1111_2222);
      issue(enc_reg(f3), 32'hFFFF_FFFF, 32'h22, 32'h3333_4444, "R3 R10 unused reg code", 1'b0, 32'h3333_4444);
    end

    // Unknown encodings (R2)
    issue(enc_imm(4, 0, 0) ^ 32'h1, 32'h0, 0, 32'hABCD_0000, "R2 wrong opcode", 1'b0, 32'hABCD_0000);
    issue({7'b0100000, 5'd4, 5'd3, 3'd4, 5'd9, 7'b0110011}, 32'h0, 0, 32'h77, "R2 other top bits", 1'b0, 32'h77);

    // Byte and halfword extension (R8)
    for (int k = 0; k < 16; k++) begin
      a = rnd();
      if (k == 0) a = 32'h1234_8080;
      if (k == 1) a = 32'h1234_7F7F;
      issue({12'h100, 5'd3, 3'b100, 5'd9, 7'b0110011}, a, 0, 32'h9, "R8 sext half", 1'b1, {{16{a[15]}}, a[15:0]});
      issue({12'h100, 5'd3, 3'b101, 5'd9, 7'b0110011}, a, 0, 32'h9, "R8 zext half", 1'b1, {16'h0, a[15:0]});
      issue({12'h100, 5'd3, 3'b110, 5'd9, 7'b0110011}, a, 0, 32'h9, "R8 sext byte", 1'b1, {{24{a[7]}}, a[7:0]});
      issue({12'h100, 5'd3, 3'b111, 5'd9, 7'b0110011}, a, 0, 32'h9, "R8 zext byte", 1'b1, {24'h0, a[7:0]});
    end
    issue({12'h100, 5'd3, 3'b000, 5'd9, 7'b0110011}, 32'hFF, 0, 32'h42, "R8 R10 low code not extension", 1'b0, 32'h42);

    // Idle cycle (R11)
    @(negedge clk);
    in_valid = 1'b0; instr = enc_imm(4, 0, 3); src_a = '0; dst_old = 32'h1;
    @(negedge clk);
    check("R11 idle", 1'b0, 1'b0, 32'h0);

    // Back-to-back stream (R1)
    @(negedge clk);
    in_valid = 1'b1; instr = enc_imm(4, 0, 3); src_a = 32'h0; dst_old = '0;
    @(negedge clk);
    check("R1 stream first", 1'b1, 1'b1, 32'h0000_000F);
    instr = enc_imm(3, 0, 3); src_a = 32'hFF;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 stream second", 1'b1, 1'b1, 32'h0000_00F0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule